// File: doc/BRIEF.md
# Execution Order Log Writer

This block sits beside a thread's logical clock and writes a compact trace of clock changes into a reserved memory region, so that an execution can later be replayed in the same inter-thread order. Each time the clock takes a new value, the block builds one 64-bit record and presents it on a valid/ready write port together with the address of the next free slot. The record holds the clock value that has just ended, the thread's identity, and how many instructions retired while that clock value was current.

Software reserves the region by loading a start pointer and an end pointer. When the region is used up, the block raises a log-full exception. Until new pointers are loaded it writes nothing and holds off the clock source. The retired-instruction counter saturates rather than wrapping. While it sits at its maximum the block asks the clock source for an increment, and that increment closes the interval through an ordinary record. The control path is a three-state machine. IDLE accepts a clock change (IDLE to SEND). SEND presents the record until the write port accepts it (SEND to IDLE, or SEND to FULL when that write used up the region). FULL holds the exception until software loads pointers (FULL to IDLE).

Top module: `order_log_writer`

## Requirements
- R1: After reset, `wr_valid`, `log_full` and `ovf_req` are low, `chg_ready` is high, and the clock, counter and both pointers are zero.
- R2: The record layout is: bits [15:0] the clock value that just ended, bits [31:16] `thread_id` sampled at the change, bits [63:32] the retired-instruction count for that clock value, zero-extended.
- R3: A record is produced only when a clock change is accepted (`chg_valid` and `chg_ready` high at an edge). `wr_valid` rises in the next cycle, and `wr_addr` carries the next-free pointer.
- R4: Each accepted write (`wr_valid` and `wr_ready` high at an edge) advances the next-free pointer by 8.
- R5: The counter restarts when a change is accepted. A retire in the acceptance cycle counts toward the new clock value and not the old one.
- R6: At most one record is pending. While `wr_valid` is high, `chg_ready` is low, and `wr_data` and `wr_addr` hold steady until the write is accepted.
- R7: When an accepted write leaves next-free + 8 at or beyond the end pointer, `log_full` rises in the next cycle and stays high. While it is high, no write is issued and `chg_ready` stays low.
- R8: A one-cycle `sw_load` loads both pointers and returns the block from FULL to IDLE. The next record is written at the loaded address.
- R9: The counter never wraps. It holds at its maximum, and `ovf_req` is high exactly while the counter is at that maximum.
- R10: Each cycle with `retire` high adds one to the count for the current clock value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| thread_id | input | 16 | Identity of the thread being traced |
| retire | input | 1 | One instruction retired this cycle |
| chg_valid | input | 1 | Clock source offers a new clock value |
| chg_clock | input | 16 | The new clock value |
| chg_ready | output | 1 | Clock change accepted this cycle |
| sw_load | input | 1 | Load both region pointers |
| sw_next | input | AW | New next-free pointer |
| sw_end | input | AW | New region end pointer |
| wr_valid | output | 1 | Record write request |
| wr_addr | output | AW | Byte address of the record |
| wr_data | output | 64 | Record contents |
| wr_ready | input | 1 | Memory side accepts the write |
| log_full | output | 1 | Region exhausted exception |
| ovf_req | output | 1 | Counter at maximum; clock increment requested |

## Verification
The record path is exercised with several patterns: retire bursts before a change, which check the count field; a retire in the same cycle as a change, which separates the old interval from the new one; back-to-back changes against a stalled write port, which test the single pending slot and the stall; and a run of changes that exhausts the region, followed by a pointer reload. A long retire burst with a narrow counter drives the count to saturation, which shows the difference between wrapping and holding and confirms when `ovf_req` is raised. A behavioural model is compared with every output on every cycle.

// File: rtl/ord_log_pkg.sv
package ord_log_pkg;

    localparam int CLK_FIELD_W = 16;
    localparam int TID_FIELD_W = 16;
    localparam int CNT_FIELD_W = 32;
    localparam int REC_W       = CLK_FIELD_W + TID_FIELD_W + CNT_FIELD_W;
    localparam int REC_BYTES   = REC_W / 8;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_SEND = 2'd1,
        ST_FULL = 2'd2
    } wr_state_e;

    // Packed MSB first: count [63:32], thread [31:16], clock [15:0]
    typedef struct packed {
        logic [CNT_FIELD_W-1:0] icnt;
        logic [TID_FIELD_W-1:0] tid;
        logic [CLK_FIELD_W-1:0] clk;
    } log_rec_t;

endpackage

// File: rtl/ord_instr_ctr.sv
module ord_instr_ctr #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             retire,
    input  logic             restart,
    output logic [CNT_W-1:0] count,
    output logic             at_max
);

    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    logic [CNT_W-1:0] cnt_q;

    assign count  = cnt_q;
    assign at_max = (cnt_q == CNT_MAX);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (restart) begin
            cnt_q <= CNT_W'(retire);
        end else if (retire && !at_max) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // R9
    no_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_q == CNT_MAX) && retire && !restart |=> cnt_q == CNT_MAX);

    // R10
    count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_q != CNT_MAX) && retire && !restart |=> cnt_q == $past(cnt_q) + 1'b1);

endmodule

// File: rtl/ord_log_ptr.sv
module ord_log_ptr #(
    parameter int AW   = 32,
    parameter int STEP = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [AW-1:0] load_next,
    input  logic [AW-1:0] load_end,
    input  logic          advance,
    output logic [AW-1:0] next_ptr,
    output logic          exhaust
);

    localparam logic [AW:0] STEP_X = (AW+1)'(STEP);

    logic [AW-1:0] next_q;
    logic [AW-1:0] end_q;

    assign next_ptr = next_q;
    // Region used up once the slot after the current one reaches the end
    assign exhaust  = ({1'b0, next_q} + STEP_X) >= {1'b0, end_q};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            next_q <= '0;
            end_q  <= '0;
        end else if (load) begin
            next_q <= load_next;
            end_q  <= load_end;
        end else if (advance) begin
            next_q <= next_q + AW'(STEP);
        end
    end

    // R4
    ptr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        advance && !load |=> next_q == $past(next_q) + AW'(STEP));

    // R8
    ptr_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> next_q == $past(load_next) && end_q == $past(load_end));

endmodule

// File: rtl/order_log_writer.sv
module order_log_writer
    import ord_log_pkg::*;
#(
    parameter int AW    = 32,
    parameter int CNT_W = 32   // 1..32, zero-extended into the record
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [15:0]   thread_id,
    input  logic          retire,
    input  logic          chg_valid,
    input  logic [15:0]   chg_clock,
    output logic          chg_ready,
    input  logic          sw_load,
    input  logic [AW-1:0] sw_next,
    input  logic [AW-1:0] sw_end,
    output logic          wr_valid,
    output logic [AW-1:0] wr_addr,
    output logic [63:0]   wr_data,
    input  logic          wr_ready,
    output logic          log_full,
    output logic          ovf_req
);

    wr_state_e state_q, state_d;
    log_rec_t  pend_q;
    logic [CLK_FIELD_W-1:0] cur_clk_q;
    logic [CNT_W-1:0] count;
    logic chg_acc, wr_acc, exhaust;

    assign chg_acc = chg_valid && (state_q == ST_IDLE);
    assign wr_acc  = wr_ready  && (state_q == ST_SEND);

    ord_instr_ctr #(.CNT_W(CNT_W)) u_ctr (
        .clk     (clk),
        .rst_n   (rst_n),
        .retire  (retire),
        .restart (chg_acc),
        .count   (count),
        .at_max  (ovf_req)
    );

    ord_log_ptr #(.AW(AW), .STEP(REC_BYTES)) u_ptr (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (sw_load),
        .load_next (sw_next),
        .load_end  (sw_end),
        .advance   (wr_acc),
        .next_ptr  (wr_addr),
        .exhaust   (exhaust)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (chg_acc) state_d = ST_SEND;
            ST_SEND: if (wr_acc)  state_d = (exhaust && !sw_load) ? ST_FULL : ST_IDLE;
            ST_FULL: if (sw_load) state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // Outputs
    always_comb begin
        chg_ready = 1'b0;
        wr_valid  = 1'b0;
        log_full  = 1'b0;
        unique case (state_q)
            ST_IDLE: chg_ready = 1'b1;
            ST_SEND: wr_valid  = 1'b1;
            ST_FULL: log_full  = 1'b1;
            default: ;
        endcase
    end

    assign wr_data = pend_q;

    // Record capture and clock tracking
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pend_q    <= '0;
            cur_clk_q <= '0;
        end else if (chg_acc) begin
            pend_q.icnt <= CNT_FIELD_W'(count);
            pend_q.tid  <= thread_id;
            pend_q.clk  <= cur_clk_q;
            cur_clk_q   <= chg_clock;
        end
    end

    // R3
    rec_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wr_valid) |-> $past(chg_valid && chg_ready));

    // R6
    wr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_valid && !wr_ready && !sw_load |=> wr_valid && $stable(wr_data) && $stable(wr_addr));

    // R6
    one_pend_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_valid |-> !chg_ready);

    // R7
    full_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        log_full && !sw_load |=> log_full && !wr_valid);

endmodule

// File: tb/sim_order_log_writer.sv
module sim_order_log_writer;

    localparam int AW   = 32;
    localparam int CW   = 4;
    localparam int CMAX = (1 << CW) - 1;

    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic          rst_n;
    logic [15:0]   thread_id;
    logic          retire;
    logic          chg_valid;
    logic [15:0]   chg_clock;
    logic          chg_ready;
    logic          sw_load;
    logic [AW-1:0] sw_next;
    logic [AW-1:0] sw_end;
    logic          wr_valid;
    logic [AW-1:0] wr_addr;
    logic [63:0]   wr_data;
    logic          wr_ready;
    logic          log_full;
    logic          ovf_req;

    order_log_writer #(.AW(AW), .CNT_W(CW)) u0 (
        .clk(clk), .rst_n(rst_n), .thread_id(thread_id), .retire(retire),
        .chg_valid(chg_valid), .chg_clock(chg_clock), .chg_ready(chg_ready),
        .sw_load(sw_load), .sw_next(sw_next), .sw_end(sw_end),
        .wr_valid(wr_valid), .wr_addr(wr_addr), .wr_data(wr_data),
        .wr_ready(wr_ready), .log_full(log_full), .ovf_req(ovf_req)
    );

    int vectors = 0;
    int miscompares = 0;

    // Behavioural reference: 0 waiting, 1 record pending, 2 region full
    int          m_mode;
    int          m_clk;
    int          m_cnt;
    logic [63:0] m_rec;
    longint      m_nxt;
    longint      m_end;

    logic [63:0] last_rec;
    logic [31:0] last_addr;
    int          n_wr;

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    endtask

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        vectors++;
        if (!ok) begin
            miscompares++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    always @(posedge clk) begin
        bit ca, wa;
        if (!rst_n) begin
            m_mode = 0; m_clk = 0; m_cnt = 0; m_rec = '0; m_nxt = 0; m_end = 0;
            n_wr = 0;
        end else begin
            ca = (m_mode == 0) && chg_valid;
            wa = (m_mode == 1) && wr_ready;
            if (wa) begin
                last_rec  = wr_data;
                last_addr = wr_addr;
                n_wr++;
            end
            if (wa) m_mode = (!sw_load && (m_nxt + 8 >= m_end)) ? 2 : 0;
            else if (m_mode == 2 && sw_load) m_mode = 0;
            else if (ca) m_mode = 1;
            if (sw_load) begin
                m_nxt = longint'(sw_next); m_end = longint'(sw_end);
            end else if (wa) m_nxt = m_nxt + 8;
            if (ca) begin
                m_rec = {32'(m_cnt), thread_id, 16'(m_clk)};
                m_clk = int'(chg_clock);
                m_cnt = retire ? 1 : 0;
            end else if (retire && m_cnt != CMAX) m_cnt++;
        end
    end

    always @(negedge clk) begin
        if (rst_n) begin
            chk(wr_valid  == (m_mode == 1), "R3 wr_valid",  64'(wr_valid),  64'(m_mode == 1));
            chk(chg_ready == (m_mode == 0), "R6 chg_ready", 64'(chg_ready), 64'(m_mode == 0));
            chk(log_full  == (m_mode == 2), "R7 log_full",  64'(log_full),  64'(m_mode == 2));
            chk(ovf_req   == (m_cnt == CMAX), "R9 ovf_req", 64'(ovf_req),   64'(m_cnt == CMAX));
            chk(64'(wr_addr) == 64'(m_nxt), "R4 wr_addr",   64'(wr_addr),   64'(m_nxt));
            if (m_mode == 1)
                chk(wr_data == m_rec, "R2 wr_data", wr_data, m_rec);
        end
    end

    task automatic change(input logic [15:0] v);
        chg_valid = 1'b1;
        chg_clock = v;
        while (!chg_ready) @(negedge clk);
        @(negedge clk);
        chg_valid = 1'b0;
    endtask

    task automatic load_ptrs(input logic [AW-1:0] n, input logic [AW-1:0] e);
        sw_load = 1'b1; sw_next = n; sw_end = e;
        @(negedge clk);
        sw_load = 1'b0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        miscompares++;
        $display("FAIL R3 watchdog actual=running expected=finished");
        summary();
        $finish;
    end

    initial begin
        int w;
        rst_n = 1'b0; thread_id = 16'h00A5; retire = 1'b0; chg_valid = 1'b0;
        chg_clock = '0; sw_load = 1'b0; sw_next = '0; sw_end = '0; wr_ready = 1'b1;
        repeat (3) @(negedge clk);
        // R1 reset state
        chk(!wr_valid && !log_full && !ovf_req && chg_ready, "R1 reset outputs",
            {60'd0, wr_valid, log_full, ovf_req, chg_ready}, 64'h1);
        chk(wr_addr == '0, "R1 reset pointer", 64'(wr_addr), 64'd0);
        rst_n = 1'b1;
        @(negedge clk);
        load_ptrs(32'h100, 32'h140);

        // R10 three retires, then a change
        retire = 1'b1;
        repeat (3) @(negedge clk);
        retire = 1'b0;
        change(16'd5);
        repeat (2) @(negedge clk);
        chk(last_rec == {32'd3, 16'h00A5, 16'd0}, "R2 R10 first record", last_rec, {32'd3, 16'h00A5, 16'd0});
        chk(last_addr == 32'h100, "R3 first address", 64'(last_addr), 64'h100);

        // R5 retire in the acceptance cycle goes to the new clock
        retire = 1'b1;
        change(16'd9);
        @(negedge clk);
        retire = 1'b0;
        repeat (2) @(negedge clk);
        chk(last_rec == {32'd0, 16'h00A5, 16'd5}, "R5 old interval", last_rec, {32'd0, 16'h00A5, 16'd5});
        change(16'd12);
        repeat (2) @(negedge clk);
        chk(last_rec == {32'd2, 16'h00A5, 16'd9}, "R5 new interval", last_rec, {32'd2, 16'h00A5, 16'd9});
        chk(last_addr == 32'h110, "R4 third address", 64'(last_addr), 64'h110);

        // R6 stalled write port, second change held off
        wr_ready = 1'b0;
        thread_id = 16'h3C01;
        change(16'd20);
        chg_valid = 1'b1; chg_clock = 16'd21;
        repeat (3) @(negedge clk);
        chk(!chg_ready && wr_valid, "R6 second change stalled", {62'd0, chg_ready, wr_valid}, 64'h1);
        wr_ready = 1'b1;
        while (!chg_ready) @(negedge clk);
        @(negedge clk);
        chg_valid = 1'b0;
        repeat (2) @(negedge clk);
        chk(last_rec == {32'd0, 16'h3C01, 16'd20}, "R6 queued record", last_rec, {32'd0, 16'h3C01, 16'd20});
        chk(last_addr == 32'h120, "R6 queued address", 64'(last_addr), 64'h120);

        // R7 exhaust the region
        change(16'd30);
        change(16'd31);
        change(16'd32);
        repeat (2) @(negedge clk);
        chk(log_full, "R7 exception raised", 64'(log_full), 64'd1);
        chk(last_addr == 32'h138, "R7 last slot", 64'(last_addr), 64'h138);
        w = n_wr;
        chg_valid = 1'b1; chg_clock = 16'd33;
        repeat (4) @(negedge clk);
        chk(n_wr == w && !chg_ready, "R7 writes blocked", 64'(n_wr), 64'(w));

        // R8 reload pointers
        load_ptrs(32'h200, 32'h400);
        while (!chg_ready) @(negedge clk);
        @(negedge clk);
        chg_valid = 1'b0;
        repeat (2) @(negedge clk);
        chk(!log_full, "R8 exception cleared", 64'(log_full), 64'd0);
        chk(last_addr == 32'h200, "R8 reloaded address", 64'(last_addr), 64'h200);

        // R9 saturation
        retire = 1'b1;
        repeat (20) @(negedge clk);
        chk(ovf_req, "R9 overflow request", 64'(ovf_req), 64'd1);
        retire = 1'b0;
        change(16'd40);
        repeat (2) @(negedge clk);
        chk(last_rec[63:32] == 32'(CMAX), "R9 saturated count", 64'(last_rec[63:32]), 64'(CMAX));
        chk(!ovf_req, "R9 request cleared", 64'(ovf_req), 64'd0);

        repeat (3) @(negedge clk);
        summary();
        $finish;
    end

endmodule